// File: doc/BRIEF.md
# Pel Color and Mask Write Transform

This unit sits at the end of a drawing pipeline and decides, one candidate destination pel at a time, whether that pel is written and with which color and mask bit. The address generator presents each pel together with its current destination color and mask bit. For print operations it also presents the source color, the source mask bit and a foreground flag. The unit applies the programmed color operation and mask operation, gates the write with the destination mask, the source transparency and the line texture, and returns the result one clock later.

Three drawing modes are supported. In monochrome mode every active pel gets the same transform pair. In bichrome mode, used for character cells, foreground and background pels each have their own pair. In polychrome mode, used for object copies, the source color is copied and the source mask bit can act as transparency. The unit also holds a 16-bit texture pattern for line and arc pens. The pattern is reloaded when a command starts and rotates by one place for each line coordinate. With short pels, one 4-bit nibble of every color operand is used, and the bank parity picks that nibble.

Top module: `pel_xform_unit`

## Requirements
- R1: During and after reset, out_valid and out_we are 0 and the texture register holds all ones, so linear pels drawn before the first command start are not blocked by the texture.
- R2: The color operation code works as follows: 0 gives color0, 1 gives color1, 2 keeps the destination color, and 3 gives the bitwise complement of the destination color.
- R3: The mask operation code works as follows: 0 clears the mask bit, 1 sets it, 2 keeps the destination mask bit, and 3 inverts it. The mask result does not depend on the color operation.
- R4: When dst_mask_use is 1, a pel whose dst_mask is 0 gives out_we=0. When dst_mask_use is 0, dst_mask has no effect on gating.
- R5: draw_mode encoding is 0 monochrome, 1 bichrome, 2 polychrome, and 3 behaves as monochrome. In bichrome mode, pel_is_fg=1 selects the foreground operations and pel_is_fg=0 selects the background operations. In monochrome mode the foreground operations are always used, whatever the value of pel_is_fg.
- R6: In polychrome mode an active pel gets the source color and keeps the destination mask bit. When src_mask_use is 1 and src_mask is 0, the pel is transparent (out_we=0).
- R7: Each pel with pel_valid=1 and pel_linear=1 rotates the texture right by one bit, whether or not the pel is written. Such a pel is drawable only if bit 0 of the texture before its rotation is 1. Non-linear pels neither step the texture nor are gated by it.
- R8: cmd_start loads tex_pattern into the texture. A pel in the same cycle as cmd_start already sees the new pattern.
- R9: When short_pel=1, color0, color1, src_color and dst_color are each reduced to their high nibble [7:4] if bank_odd=1, or their low nibble [3:0] if bank_odd=0. The result is in out_color[3:0] and out_color[7:4] is 0. The complement is then a 4-bit complement.
- R10: Every output is registered. A pel presented at one clock edge appears on the outputs after that edge, with out_valid=1. A cycle without a pel gives out_valid=0. A rejected pel gives out_we=0 with out_color and out_mask equal to the (lane-reduced) destination values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Command start; reloads the texture |
| tex_pattern | input | 16 | Programmed line texture |
| pel_valid | input | 1 | A candidate pel is present |
| pel_linear | input | 1 | Pel is a line/arc coordinate (texture applies) |
| draw_mode | input | 2 | 0 mono, 1 bichrome, 2 polychrome, 3 as mono |
| fg_color_op | input | 2 | Foreground color operation |
| fg_mask_op | input | 2 | Foreground mask operation |
| bg_color_op | input | 2 | Background color operation |
| bg_mask_op | input | 2 | Background mask operation |
| color0 | input | 8 | First color register |
| color1 | input | 8 | Second color register |
| dst_mask_use | input | 1 | Gate writes with destination mask bit |
| src_mask_use | input | 1 | Treat clear source mask as transparent |
| pel_is_fg | input | 1 | Pel is a foreground element |
| src_color | input | 8 | Source pel color |
| src_mask | input | 1 | Source pel mask bit |
| dst_color | input | 8 | Current destination color |
| dst_mask | input | 1 | Current destination mask bit |
| short_pel | input | 1 | 4-bit pel lane selection active |
| bank_odd | input | 1 | Bank parity for lane selection |
| out_valid | output | 1 | Result present |
| out_we | output | 1 | Pel is to be written |
| out_color | output | 8 | New color |
| out_mask | output | 1 | New mask bit |

## Verification
Most of the state is one cycle deep. A wrong decode of an operation, mode or lane therefore shows up on out_color or out_mask in the cycle right after the offending pel. The texture register is the only long-lived state. If it rotates the wrong way, steps on the wrong pels or misses a reload, the error appears only as a wrong out_we on some later line pel, and it can take up to sixteen line pels to appear. For that reason the bench runs long, irregular line sequences with non-linear pels interleaved. It also compares every cycle against a behavioural model that keeps its own texture copy.

// File: rtl/pel_xform_pkg.sv
package pel_xform_pkg;
  typedef enum logic [1:0] {
    COP_C0   = 2'd0,
    COP_C1   = 2'd1,
    COP_KEEP = 2'd2,
    COP_INV  = 2'd3
  } color_op_e;

  typedef enum logic [1:0] {
    MOP_CLR  = 2'd0,
    MOP_SET  = 2'd1,
    MOP_KEEP = 2'd2,
    MOP_INV  = 2'd3
  } mask_op_e;

  typedef enum logic [1:0] {
    DM_MONO = 2'd0,
    DM_BI   = 2'd1,
    DM_POLY = 2'd2,
    DM_RSVD = 2'd3
  } draw_mode_e;
endpackage

// File: rtl/pel_lane_sel.sv
module pel_lane_sel #(
  parameter int COLOR_W = 8
) (
  input  logic               short_pel,
  input  logic               bank_odd,
  input  logic [COLOR_W-1:0] color_in,
  output logic [COLOR_W-1:0] color_out
);
  localparam int NIB_W = COLOR_W / 2;

  logic [NIB_W-1:0] nib;

  always_comb begin
    nib = bank_odd ? color_in[COLOR_W-1:NIB_W] : color_in[NIB_W-1:0];
    if (short_pel) color_out = {{(COLOR_W-NIB_W){1'b0}}, nib};
    else           color_out = color_in;
  end
endmodule

// File: rtl/pel_color_op.sv
module pel_color_op
  import pel_xform_pkg::*;
#(
  parameter int COLOR_W = 8
) (
  input  color_op_e          op,
  input  logic [COLOR_W-1:0] c0,
  input  logic [COLOR_W-1:0] c1,
  input  logic [COLOR_W-1:0] dst,
  input  logic [COLOR_W-1:0] lane_mask,
  output logic [COLOR_W-1:0] result
);
  always_comb begin
    unique case (op)
      COP_C0:   result = c0;
      COP_C1:   result = c1;
      COP_KEEP: result = dst;
      COP_INV:  result = ~dst & lane_mask;
      default:  result = dst;
    endcase
  end
endmodule

// File: rtl/pel_mask_op.sv
module pel_mask_op
  import pel_xform_pkg::*;
(
  input  mask_op_e op,
  input  logic     dst,
  output logic     result
);
  always_comb begin
    unique case (op)
      MOP_CLR:  result = 1'b0;
      MOP_SET:  result = 1'b1;
      MOP_KEEP: result = dst;
      MOP_INV:  result = ~dst;
      default:  result = dst;
    endcase
  end
endmodule

// File: rtl/pel_texture.sv
module pel_texture #(
  parameter int TEX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TEX_W-1:0] pattern,
  input  logic             step,
  output logic             gate_bit
);
  logic [TEX_W-1:0] tex_q;
  logic [TEX_W-1:0] tex_cur;
  logic [TEX_W-1:0] tex_d;
  logic             tex_en;

  always_comb begin
    tex_cur  = load ? pattern : tex_q;
    gate_bit = tex_cur[0];
    tex_d    = step ? {tex_cur[0], tex_cur[TEX_W-1:1]} : tex_cur;
    tex_en   = load | step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tex_q <= '1;
    else if (tex_en) tex_q <= tex_d;
  end

  // rotation must neither create nor lose set bits between reloads
  assert_tex_rotate_keeps_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($countones(tex_q) == $countones($past(tex_q))));
endmodule

// File: rtl/pel_xform_unit.sv
module pel_xform_unit
  import pel_xform_pkg::*;
#(
  parameter int COLOR_W = 8,
  parameter int TEX_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_start,
  input  logic [TEX_W-1:0]   tex_pattern,
  input  logic               pel_valid,
  input  logic               pel_linear,
  input  logic [1:0]         draw_mode,
  input  logic [1:0]         fg_color_op,
  input  logic [1:0]         fg_mask_op,
  input  logic [1:0]         bg_color_op,
  input  logic [1:0]         bg_mask_op,
  input  logic [COLOR_W-1:0] color0,
  input  logic [COLOR_W-1:0] color1,
  input  logic               dst_mask_use,
  input  logic               src_mask_use,
  input  logic               pel_is_fg,
  input  logic [COLOR_W-1:0] src_color,
  input  logic               src_mask,
  input  logic [COLOR_W-1:0] dst_color,
  input  logic               dst_mask,
  input  logic               short_pel,
  input  logic               bank_odd,
  output logic               out_valid,
  output logic               out_we,
  output logic [COLOR_W-1:0] out_color,
  output logic               out_mask
);
  localparam int NIB_W    = COLOR_W / 2;
  localparam int N_LANES  = 4;

  // lane-reduced operands: 0 color0, 1 color1, 2 source, 3 destination
  logic [COLOR_W-1:0] lane_in  [N_LANES];
  logic [COLOR_W-1:0] lane_out [N_LANES];
  logic [COLOR_W-1:0] lane_mask;

  always_comb begin
    lane_in[0] = color0;
    lane_in[1] = color1;
    lane_in[2] = src_color;
    lane_in[3] = dst_color;
    lane_mask  = short_pel ? {{(COLOR_W-NIB_W){1'b0}}, {NIB_W{1'b1}}} : '1;
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    pel_lane_sel #(.COLOR_W(COLOR_W)) u_lane (
      .short_pel (short_pel),
      .bank_odd  (bank_odd),
      .color_in  (lane_in[g]),
      .color_out (lane_out[g])
    );
  end

  // mode and operation selection
  draw_mode_e mode_eff;
  color_op_e  cop_sel;
  mask_op_e   mop_sel;

  always_comb begin
    mode_eff = (draw_mode_e'(draw_mode) == DM_RSVD) ? DM_MONO : draw_mode_e'(draw_mode);
    if (mode_eff == DM_BI && !pel_is_fg) begin
      cop_sel = color_op_e'(bg_color_op);
      mop_sel = mask_op_e'(bg_mask_op);
    end else begin
      cop_sel = color_op_e'(fg_color_op);
      mop_sel = mask_op_e'(fg_mask_op);
    end
  end

  logic [COLOR_W-1:0] op_color;
  logic               op_mask;

  pel_color_op #(.COLOR_W(COLOR_W)) u_cop (
    .op        (cop_sel),
    .c0        (lane_out[0]),
    .c1        (lane_out[1]),
    .dst       (lane_out[3]),
    .lane_mask (lane_mask),
    .result    (op_color)
  );

  pel_mask_op u_mop (
    .op     (mop_sel),
    .dst    (dst_mask),
    .result (op_mask)
  );

  logic tex_gate;

  pel_texture #(.TEX_W(TEX_W)) u_tex (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cmd_start),
    .pattern  (tex_pattern),
    .step     (pel_valid & pel_linear),
    .gate_bit (tex_gate)
  );

  // gating and next-state
  logic               dmask_ok;
  logic               smask_ok;
  logic               tex_ok;
  logic               active;
  logic               valid_d;
  logic               we_d;
  logic [COLOR_W-1:0] color_d;
  logic               mask_d;

  always_comb begin
    dmask_ok = !dst_mask_use || dst_mask;
    smask_ok = !(mode_eff == DM_POLY && src_mask_use && !src_mask);
    tex_ok   = !pel_linear || tex_gate;
    active   = pel_valid && dmask_ok && smask_ok && tex_ok;
    valid_d  = pel_valid;
    we_d     = active;
    if (!active) begin
      color_d = lane_out[3];
      mask_d  = dst_mask;
    end else if (mode_eff == DM_POLY) begin
      color_d = lane_out[2];
      mask_d  = dst_mask;
    end else begin
      color_d = op_color;
      mask_d  = op_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
      out_color <= '0;
      out_mask  <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_we    <= we_d;
      out_color <= color_d;
      out_mask  <= mask_d;
    end
  end

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pel_valid |=> out_valid);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pel_valid |=> (!out_valid && !out_we));
  assert_dst_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pel_valid && dst_mask_use && !dst_mask) |=> (out_valid && !out_we && !out_mask));
  assert_src_transparent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pel_valid && draw_mode == 2'd2 && src_mask_use && !src_mask) |=> !out_we);
  assert_poly_mask_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pel_valid && draw_mode == 2'd2) |=> (out_mask == $past(dst_mask)));
  assert_short_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pel_valid && short_pel) |=> (out_color[COLOR_W-1:NIB_W] == '0));
endmodule

// File: tb/pel_xform_unit_test.sv
`timescale 1ns/1ps
module pel_xform_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_start, pel_valid, pel_linear;
  logic [15:0] tex_pattern;
  logic [1:0]  draw_mode, fg_color_op, fg_mask_op, bg_color_op, bg_mask_op;
  logic [7:0]  color0, color1, src_color, dst_color;
  logic        dst_mask_use, src_mask_use, pel_is_fg, src_mask, dst_mask;
  logic        short_pel, bank_odd;
  logic        out_valid, out_we, out_mask;
  logic [7:0]  out_color;

  int total = 0;
  int bad = 0;
  int mtex;
  bit done = 0;
  bit e_v, e_we;
  int e_c, e_m;
  int lfsr = 32'h1ACE;

  always #4 clk = ~clk;

  pel_xform_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .tex_pattern(tex_pattern),
    .pel_valid(pel_valid), .pel_linear(pel_linear), .draw_mode(draw_mode),
    .fg_color_op(fg_color_op), .fg_mask_op(fg_mask_op),
    .bg_color_op(bg_color_op), .bg_mask_op(bg_mask_op),
    .color0(color0), .color1(color1), .dst_mask_use(dst_mask_use),
    .src_mask_use(src_mask_use), .pel_is_fg(pel_is_fg), .src_color(src_color),
    .src_mask(src_mask), .dst_color(dst_color), .dst_mask(dst_mask),
    .short_pel(short_pel), .bank_odd(bank_odd), .out_valid(out_valid),
    .out_we(out_we), .out_color(out_color), .out_mask(out_mask)
  );

  function automatic int lane(int v);
    if (!short_pel) return v & 255;
    return bank_odd ? ((v >> 4) & 15) : (v & 15);
  endfunction

  // behavioural reference: evaluates the current inputs and advances its own texture copy
  task automatic model();
    int m, cop, mop, c0, c1, s, d, tcur, tbit;
    bit gate;
    m = (draw_mode == 2'd3) ? 0 : int'(draw_mode);
    if (m == 1 && !pel_is_fg) begin cop = bg_color_op; mop = bg_mask_op; end
    else begin cop = fg_color_op; mop = fg_mask_op; end
    c0 = lane(color0); c1 = lane(color1); s = lane(src_color); d = lane(dst_color);
    tcur = cmd_start ? int'(tex_pattern) : mtex;
    tbit = tcur % 2;
    if (pel_valid && pel_linear) tcur = (tcur >> 1) | ((tcur % 2) << 15);
    mtex = tcur;
    gate = pel_valid && (!dst_mask_use || dst_mask) && (!pel_linear || tbit == 1)
           && !(m == 2 && src_mask_use && !src_mask);
    e_v = pel_valid;
    e_we = gate;
    if (!gate) begin e_c = d; e_m = dst_mask; end
    else if (m == 2) begin e_c = s; e_m = dst_mask; end
    else begin
      case (cop)
        0: e_c = c0;
        1: e_c = c1;
        2: e_c = d;
        default: e_c = short_pel ? ((~d) & 15) : ((~d) & 255);
      endcase
      case (mop)
        0: e_m = 0;
        1: e_m = 1;
        2: e_m = dst_mask;
        default: e_m = dst_mask ? 0 : 1;
      endcase
    end
  endtask

  task automatic tick(string req);
    model();
    @(posedge clk);
    @(negedge clk);
    total++;
    if (out_valid !== e_v || (e_v && (out_we !== e_we || int'(out_color) != e_c || int'(out_mask) != e_m))) begin
      bad++;
      $display("FAIL %s actual v=%0b we=%0b c=%0h m=%0b expected v=%0b we=%0b c=%0h m=%0b",
               req, out_valid, out_we, out_color, out_mask, e_v, e_we, e_c, e_m);
    end
    cmd_start = 1'b0;
  endtask

  task automatic quiet();
    cmd_start = 0; pel_valid = 0; pel_linear = 0; tex_pattern = 16'h0;
    draw_mode = 0; fg_color_op = 0; fg_mask_op = 2; bg_color_op = 0; bg_mask_op = 2;
    color0 = 8'h3C; color1 = 8'hA5; src_color = 8'h96; dst_color = 8'h71;
    dst_mask_use = 0; src_mask_use = 0; pel_is_fg = 1; src_mask = 1; dst_mask = 0;
    short_pel = 0; bank_odd = 0;
  endtask

  function automatic int rnd();
    lfsr = (lfsr >> 1) ^ ((lfsr % 2 == 1) ? 32'h8000_0057 : 0);
    return lfsr;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    quiet();
    mtex = 16'hFFFF;
    rst_n = 0;
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_we !== 1'b0) begin
      bad++; $display("FAIL R1 actual v=%0b we=%0b expected v=0 we=0", out_valid, out_we);
    end
    rst_n = 1;
    @(negedge clk);
    tick("R1");
    // R1: texture comes out of reset as all ones, so line pels draw
    pel_valid = 1; pel_linear = 1; fg_color_op = 1;
    repeat (3) tick("R1");
    pel_linear = 0;
    // R2: each color operation in monochrome mode
    for (int op = 0; op < 4; op++) begin
      fg_color_op = op[1:0];
      dst_color = 8'h71; tick("R2");
      dst_color = 8'hF0; tick("R2");
    end
    // R3: each mask operation against both destination mask values
    for (int op = 0; op < 4; op++) begin
      fg_mask_op = op[1:0]; fg_color_op = 3 - op[1:0];
      dst_mask = 0; tick("R3");
      dst_mask = 1; tick("R3");
    end
    // R4: destination mask gating on and off
    fg_color_op = 1; fg_mask_op = 3;
    dst_mask_use = 1; dst_mask = 0; tick("R4");
    dst_mask = 1; tick("R4");
    dst_mask_use = 0; dst_mask = 0; tick("R4");
    // R5: bichrome separate pairs; monochrome ignores the flag; code 3 acts as mono
    bg_color_op = 3; bg_mask_op = 1; fg_color_op = 0; fg_mask_op = 0; dst_mask = 1;
    for (int md = 0; md < 4; md++) begin
      if (md == 2) continue;
      draw_mode = md[1:0];
      pel_is_fg = 1; tick("R5");
      pel_is_fg = 0; tick("R5");
    end
    // R6: polychrome copy and source transparency
    draw_mode = 2; fg_mask_op = 1;
    src_mask_use = 0; src_mask = 0; tick("R6");
    src_mask_use = 1; src_mask = 0; tick("R6");
    src_mask = 1; src_color = 8'h5A; dst_mask = 0; tick("R6");
    dst_mask_use = 1; tick("R6");
    dst_mask_use = 0; draw_mode = 0; src_mask_use = 0;
    // R8 then R7: reload with a pel in the same cycle, then step with interleaved non-linear pels
    tex_pattern = 16'hA5C2; cmd_start = 1; pel_linear = 1; fg_color_op = 1; fg_mask_op = 1;
    tick("R8");
    for (int i = 0; i < 40; i++) begin
      pel_linear = (i % 5 != 3);
      pel_valid = (i % 7 != 6);
      dst_mask_use = (i % 9 == 4); dst_mask = 0;
      tick("R7");
    end
    pel_valid = 1; dst_mask_use = 0;
    tex_pattern = 16'h0001; cmd_start = 1; pel_valid = 0; tick("R8");
    pel_valid = 1; pel_linear = 1;
    repeat (18) tick("R8");
    pel_linear = 0;
    // R9: short pels on both bank parities, complement limited to the lane
    short_pel = 1; color0 = 8'h3C; color1 = 8'hA5; dst_color = 8'h71; src_color = 8'hE4;
    for (int op = 0; op < 4; op++) begin
      fg_color_op = op[1:0];
      bank_odd = 0; tick("R9");
      bank_odd = 1; tick("R9");
    end
    draw_mode = 2; bank_odd = 1; tick("R9");
    short_pel = 0; draw_mode = 0;
    // R10: idle cycles and a long mixed sweep
    pel_valid = 0; repeat (2) tick("R10");
    for (int i = 0; i < 400; i++) begin
      int r;
      r = rnd();
      pel_valid = r[0]; pel_linear = r[1]; draw_mode = r[3:2];
      fg_color_op = r[5:4]; fg_mask_op = r[7:6]; bg_color_op = r[9:8]; bg_mask_op = r[11:10];
      dst_mask_use = r[12]; src_mask_use = r[13]; pel_is_fg = r[14]; src_mask = r[15];
      dst_mask = r[16]; short_pel = r[17]; bank_odd = r[18];
      cmd_start = (r[23:19] == 0); tex_pattern = r[31:16];
      r = rnd();
      color0 = r[7:0]; color1 = r[15:8]; src_color = r[23:16]; dst_color = r[31:24];
      tick("R10");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule